// File: doc/BRIEF.md
# Falling-Edge Pin Event Capture with Shared Interrupt

This block watches an input port of `WIDTH` pins and records falling edges on the pins the master has armed. Each pin has one arm bit in an enable register. When an armed pin goes from high to low, a matching sticky bit in the event status register is set. The bit stays set until the master clears it. The active-low interrupt line is the NOR of all status bits, so it stays low while any event is pending.

The pins may be asynchronous to `clk`. Each pin passes through a two-flop synchroniser, and a register holding the previous synchronised value is used to detect the 1-to-0 step. The master reads `evt_status` to learn which pins fired. It then issues the clear opcode (0x13) on the command strobe, which empties the status register as a group. Configuration and commands are single-cycle strobes that the block takes on every clock edge, so there is no back-pressure and no ready signal. The enable and status registers are always visible on plain output pins.

Top module: `pin_event_irq`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), `evt_status` and `irq_enable` are all zeros and `irq_n` is 1.
- R2: A clock edge with `cfg_we` high loads `cfg_enable` into `irq_enable`. Bit i of `irq_enable` arms pin i (1 = armed, 0 = off).
- R3: Pin i is sampled high at edge k-1 and low at edge k, and bit i of `irq_enable` is 1 before edge k+2. Then bit i of `evt_status` is 1 after edge k+2 and not before.
- R4: A status bit stays set when its pin returns high or sees further edges, until a clear command is taken.
- R5: `irq_n` is 0 exactly when at least one bit of `evt_status` is 1, and 1 otherwise.
- R6: A clock edge with `cmd_valid` high and `cmd_op` equal to 0x13 clears every bit of `evt_status`.
- R7: A command with any other `cmd_op` value leaves `evt_status` unchanged.
- R8: If a new falling edge would set bit i at the same edge at which a clear is taken, bit i ends up set and all the other bits are cleared.
- R9: Rising edges, and falling edges on pins whose arm bit is 0, never set a status bit.
- R10: The arm bit is taken at the detection edge (k+2). A `cfg_we` write at that same edge affects only later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | WIDTH | Monitored input pins, may be asynchronous |
| cfg_we | input | 1 | Strobe that loads the arm register |
| cfg_enable | input | WIDTH | New arm register value |
| cmd_valid | input | 1 | Command strobe, taken every edge it is high |
| cmd_op | input | 8 | Command opcode; 0x13 clears all events |
| irq_enable | output | WIDTH | Current arm register |
| evt_status | output | WIDTH | Sticky falling-edge event flags |
| irq_n | output | 1 | Shared interrupt, low while any event is pending |

## Verification
The bench keeps its own three-deep history of the pin values it drove. Using that history, it expects a status bit two edges after the edge that first samples a pin low, which is edge k+2 in R3. Arm writes and clear commands are expected to act on the edge where they are sampled, and `irq_n` is expected to follow the status register with no added cycle. All outputs are compared at the falling clock edge against a model updated at each rising edge. The directed checks count edges one by one, so a result that is one cycle early or late is caught: for example, the status bit must still be 0 after edge k+1 and must be 1 after edge k+2.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] OP_EVT_CLEAR = 8'h13;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[LAST];
  end
endmodule

// File: rtl/pin_event_fall_detect.sv
module pin_event_fall_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_i;
  end

  // previous high, current low
  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/pin_event_status.sv
module pin_event_status
  import pin_event_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] fall_i,
  input  logic             cfg_we,
  input  logic [WIDTH-1:0] cfg_enable,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  output logic [WIDTH-1:0] enable_o,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_n
);
  logic [WIDTH-1:0] enable_q;
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] keep;
  logic             clear;

  assign clear = cmd_valid && (cmd_op == OP_EVT_CLEAR);
  assign hit   = fall_i & enable_q;
  assign keep  = clear ? '0 : status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enable_q <= '0;
    else if (cfg_we) enable_q <= cfg_enable;
  end

  // new events win over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= keep | hit;
  end

  assign enable_o = enable_q;
  assign status_o = status_q;
  assign irq_n    = ~|status_q;
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_event_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             cfg_we,
  input  logic [WIDTH-1:0] cfg_enable,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  output logic [WIDTH-1:0] irq_enable,
  output logic [WIDTH-1:0] evt_status,
  output logic             irq_n
);
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] pins_fall;

  pin_event_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_i),
    .sync_o  (pins_sync)
  );

  pin_event_fall_detect #(.WIDTH(WIDTH)) u_fall (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pins_sync),
    .fall_o  (pins_fall)
  );

  pin_event_status #(.WIDTH(WIDTH)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (pins_fall),
    .cfg_we     (cfg_we),
    .cfg_enable (cfg_enable),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .enable_o   (irq_enable),
    .status_o   (evt_status),
    .irq_n      (irq_n)
  );
endmodule

// File: rtl/pin_event_irq_checker.sv
module pin_event_irq_checker
  import pin_event_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [WIDTH-1:0] cfg_enable,
  input logic             cmd_valid,
  input logic [OP_W-1:0]  cmd_op,
  input logic [WIDTH-1:0] irq_enable,
  input logic [WIDTH-1:0] evt_status,
  input logic             irq_n
);
  logic is_clear;
  assign is_clear = cmd_valid && (cmd_op == OP_EVT_CLEAR);

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (evt_status == '0 && irq_enable == '0 && irq_n));

  p_arm_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> irq_enable == $past(cfg_enable));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_clear |=> (evt_status & $past(evt_status)) == $past(evt_status));

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_status != '0) == !irq_n);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear |=> (evt_status & $past(evt_status) & ~$past(irq_enable)) == '0);

  p_armed_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_status & ~$past(evt_status) & ~$past(irq_enable)) == '0);
endmodule

bind pin_event_irq pin_event_irq_checker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_enable (cfg_enable),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .irq_enable (irq_enable),
  .evt_status (evt_status),
  .irq_n      (irq_n)
);

// File: tb/test_pin_event_irq.sv
module test_pin_event_irq;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins_i = '0;
  logic         cfg_we = 1'b0;
  logic [W-1:0] cfg_enable = '0;
  logic         cmd_valid = 1'b0;
  logic [7:0]   cmd_op = '0;
  logic [W-1:0] irq_enable;
  logic [W-1:0] evt_status;
  logic         irq_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  string st_tag = "R3";

  // model state
  logic [W-1:0] m_en = '0, m_st = '0, h1 = '0, h2 = '0, h3 = '0;

  always #2 clk = ~clk;

  pin_event_irq #(.WIDTH(W)) i_pin_event_irq (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cfg_we(cfg_we),
    .cfg_enable(cfg_enable), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .irq_enable(irq_enable), .evt_status(evt_status), .irq_n(irq_n)
  );

  function automatic logic [W-1:0] next_status(logic [W-1:0] st, logic [W-1:0] en,
      logic [W-1:0] p2, logic [W-1:0] p3, logic clr);
    return (clr ? '0 : st) | (~p2 & p3 & en);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_st = '0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      m_st = next_status(m_st, m_en, h2, h3, cmd_valid && cmd_op == 8'h13);
      if (cfg_we) m_en = cfg_enable;
      h3 = h2; h2 = h1; h1 = pins_i;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check(st_tag, "status", 32'(evt_status), 32'(m_st));
    check("R5", "irq_n", 32'(irq_n), 32'(m_st == '0));
    check("R2", "enable", 32'(irq_enable), 32'(m_en));
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_cmd(logic [7:0] op);
    cmd_valid = 1'b1; cmd_op = op; tick(); cmd_valid = 1'b0;
  endtask

  task automatic write_en(logic [W-1:0] v);
    cfg_we = 1'b1; cfg_enable = v; tick(); cfg_we = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) tick();
    // R1 reset state
    check("R1", "status at reset", 32'(evt_status), 0);
    check("R1", "irq_n at reset", 32'(irq_n), 1);
    check("R1", "enable at reset", 32'(irq_enable), 0);
    rst_n = 1'b1;
    tick();
    // R2 arm all
    write_en('1);
    check("R2", "arm all", 32'(irq_enable), 32'hFF);
    // R9 rising edges only
    st_tag = "R9";
    pins_i = '1; repeat (5) tick();
    check("R9", "rising edges", 32'(evt_status), 0);
    // R3 timing: drop pin3 before edge k
    st_tag = "R3";
    pins_i[3] = 1'b0; tick();        // after edge k
    tick();                          // after edge k+1
    check("R3", "not yet k+1", 32'(evt_status), 0);
    tick();                          // after edge k+2
    check("R3", "set at k+2", 32'(evt_status), 32'h08);
    check("R5", "irq low", 32'(irq_n), 0);
    // R4 sticky
    st_tag = "R4";
    pins_i[3] = 1'b1; repeat (4) tick();
    check("R4", "sticky", 32'(evt_status), 32'h08);
    // R7 other opcode
    st_tag = "R7";
    pulse_cmd(8'h12); tick();
    check("R7", "other opcode", 32'(evt_status), 32'h08);
    pulse_cmd(8'h93);
    check("R7", "other opcode 2", 32'(evt_status), 32'h08);
    // R6 clear
    st_tag = "R6";
    pulse_cmd(8'h13);
    check("R6", "cleared", 32'(evt_status), 0);
    check("R5", "irq high", 32'(irq_n), 1);
    // R9 disabled pin
    st_tag = "R9";
    write_en(8'h0F);
    pins_i[6] = 1'b0; repeat (4) tick();
    check("R9", "disarmed pin", 32'(evt_status), 0);
    pins_i[6] = 1'b1; repeat (3) tick();
    // R8 fall coincides with clear; pin0 preset then pin1 falls at clear edge
    st_tag = "R8";
    pins_i[0] = 1'b0; repeat (4) tick();
    check("R8", "preset pin0", 32'(evt_status), 32'h01);
    pins_i[1] = 1'b0; tick(); tick(); // after edges k, k+1
    pulse_cmd(8'h13);                  // clear at edge k+2
    check("R8", "new event wins", 32'(evt_status), 32'h02);
    pins_i[0] = 1'b1; pins_i[1] = 1'b1; repeat (3) tick();
    pulse_cmd(8'h13);
    // R10 disarm at the detection edge
    st_tag = "R10";
    pins_i[2] = 1'b0; tick(); tick();
    write_en(8'h00);                   // write at edge k+2
    check("R10", "old arm used", 32'(evt_status), 32'h04);
    check("R10", "new arm loaded", 32'(irq_enable), 0);
    pins_i[2] = 1'b1; repeat (3) tick();
    pins_i[2] = 1'b0; repeat (4) tick();
    check("R10", "later edge ignored", 32'(evt_status), 32'h04);
    // random phase
    st_tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      pins_i    = W'($urandom);
      cfg_we    = ($urandom % 16) == 0;
      cfg_enable = W'($urandom);
      cmd_valid = ($urandom % 6) == 0;
      cmd_op    = (($urandom % 3) == 0) ? 8'($urandom) : 8'h13;
      tick();
    end
    cfg_we = 1'b0; cmd_valid = 1'b0;
    tick();
    finish_run();
  end
endmodule